// File: doc/BRIEF.md
# Stereo PWM Audio DAC Controller

This block is an audio playback peripheral that converts 16-bit PCM samples into two pulse-width-modulated pins, one per stereo channel. Each pin feeds an external RC low-pass filter, which recovers the analogue waveform. Everything runs on one core clock. The block counts the PWM period in core-clock cycles and holds each sample for a programmable number of periods, so the core clock rate, the PWM resolution and the repeat count together set the sample rate. For example, with 8-bit resolution, a 12.288 MHz core clock and one period per sample give 48 kHz.

Software or a DMA engine writes samples into a one-entry holding buffer through a small register window. The block raises a transmit request whenever playback is enabled and the buffer is empty. The active sample advances only when a sample period closes. If the buffer is empty at that moment, the previous sample keeps playing.

A control register configures playback:
- PWM resolution.
- Pulse alignment.
- Repeat count.
- Channel swap.
- MSB inversion, which turns two's-complement samples into offset binary.
- A left shift of the data.

Top module: `pwmdac_top`

## Requirements
- R1: After reset both PWM pins and the transmit request are low, the control register is zero and the holding buffer is empty. Until the first sample is loaded, the active sample is zero.
- R2: The control register is written at byte offset 4, and bit 0 of it enables playback. While bit 0 is clear, both pins go low one cycle later and the period and repeat counters return to zero. The active sample is kept, and it plays in the first periods after playback is enabled again.
- R3: Control bit 1 selects the PWM period: 0 gives 256 core clocks with an 8-bit duty, and 1 gives 1024 core clocks with a 10-bit duty.
- R4: Control bits 3:2 set the pulse alignment for a duty d in a period of P clocks:
  - 0 (left): high for the first d clocks.
  - 1 (right): high for the last d clocks, starting at clock P-d.
  - 2 (centre): high for d clocks starting at clock floor((P-d)/2).
  - 3: behaves as centre.
- R5: Control bits 12:4 hold N-1, and each sample plays for N consecutive PWM periods, where N ranges from 1 to 512.
- R6: The sample register is written at byte offset 0.
  - A 32-bit write puts data bits 15:0 on the left channel and bits 31:16 on the right channel.
  - A 16-bit write uses data bits 15:0 for both channels and ignores bits 31:16.
- R7: The duty is formed from the 16-bit sample in three steps:
  - If control bit 14 is set, sample bit 15 is inverted.
  - The result is shifted left by control bits 17:15, and bits shifted beyond bit 15 are dropped.
  - The duty is bits 15:8 of the shifted value (8-bit mode) or bits 15:6 (10-bit mode).
- R8: When control bit 13 is set, the left pin is modulated from the right sample and the right pin from the left sample.
- R9: Sample loading and the transmit request follow these rules:
  - The buffered sample becomes active only at the end of the last repeat period.
  - The transmit request is high exactly while playback is enabled and the buffer is empty.
  - If the buffer is empty when a sample is due (underrun), the previous sample keeps playing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; its rate sets the sample rate |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Byte offset of the written register |
| regWide | input | 1 | 1 for a 32-bit sample write, 0 for a 16-bit one |
| regWdata | input | 32 | Write data |
| txReq | output | 1 | Request for a new sample |
| pwmLeft | output | 1 | Left channel PWM pin |
| pwmRight | output | 1 | Right channel PWM pin |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 8-bit and 10-bit resolutions, and a 9-bit repeat field. With these, every alignment, both period lengths, the largest shift and the reserved alignment code can be covered within a few thousand cycles. Repeat counts stay at one and two, which is enough to show a sample being held across several periods and an underrun occurring on a multi-period boundary. For every period, the bench measures the high time and the first high clock on each pin and compares them with values it computes from the written sample and configuration.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;
  parameter int SMP_W   = 16;
  parameter int LO_BITS = 8;
  parameter int HI_BITS = 10;
  parameter int REP_W   = 9;
  parameter int SHIFT_W = 3;
  localparam int CNT_W  = HI_BITS;
  localparam int DATA_W = 2 * SMP_W;

  typedef enum logic [1:0] {
    ALIGN_LEFT   = 2'd0,
    ALIGN_RIGHT  = 2'd1,
    ALIGN_CENTRE = 2'd2,
    ALIGN_RSVD   = 2'd3
  } align_e;

  // Packed MSB first so that a write of the control word maps bit for bit.
  typedef struct packed {
    logic [SHIFT_W-1:0] shift;     // 17:15
    logic               signMode;  // 14
    logic               swap;      // 13
    logic [REP_W-1:0]   repM1;     // 12:4
    align_e             align;     // 3:2
    logic               hiRes;     // 1
    logic               enable;    // 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef struct packed {
    logic bufWrite;
    logic bufWide;
    logic load;
  } strobe_t;
endpackage

// File: rtl/pwmdac_chan.sv
module pwmdac_chan
  import pwmdac_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               hiRes,
  input  align_e             align,
  input  logic               signMode,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [SMP_W-1:0]   raw,
  input  logic [CNT_W-1:0]   phase,
  output logic               pwm
);
  localparam int PW = CNT_W + 1;

  logic [SMP_W-1:0] flipped;
  logic [SMP_W-1:0] shifted;
  logic [PW-1:0]    duty;
  logic [PW-1:0]    period;
  logic [PW-1:0]    ph;
  logic [PW-1:0]    lo;
  logic             hit;

  always_comb begin
    flipped = raw ^ {signMode, {(SMP_W-1){1'b0}}};
    shifted = flipped << shift;
    if (hiRes) begin
      duty   = PW'(shifted[SMP_W-1 -: HI_BITS]);
      period = PW'(1 << HI_BITS);
    end else begin
      duty   = PW'(shifted[SMP_W-1 -: LO_BITS]);
      period = PW'(1 << LO_BITS);
    end
    ph = PW'(phase);
    lo = (period - duty) >> 1;
    case (align)
      ALIGN_LEFT:  hit = ph < duty;
      ALIGN_RIGHT: hit = ph >= (period - duty);
      default:     hit = (ph >= lo) && (ph < lo + duty);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwm <= 1'b0;
    else       pwm <= enable && hit;
  end

  p_off_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pwm);
endmodule

// File: rtl/pwmdac_ctrl.sv
module pwmdac_ctrl
  import pwmdac_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWide,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output ctrl_t             cfg,
  output logic [CNT_W-1:0]  phase,
  output strobe_t           stb,
  output logic              txReq
);
  localparam logic [ADDR_W-1:0] OFS_SAMPLE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'(4);
  localparam logic [CNT_W-1:0]  MAX_LO     = CNT_W'((1 << LO_BITS) - 1);
  localparam logic [CNT_W-1:0]  MAX_HI     = CNT_W'((1 << HI_BITS) - 1);

  logic [REP_W-1:0] repCnt;
  logic             bufValid;
  logic [CNT_W-1:0] phaseMax;
  logic             periodEnd;
  logic             sampleDue;
  logic             wrSample;
  logic             wrCtrl;

  always_comb begin
    wrSample  = regWe && (regAddr == OFS_SAMPLE);
    wrCtrl    = regWe && (regAddr == OFS_CTRL);
    phaseMax  = cfg.hiRes ? MAX_HI : MAX_LO;
    periodEnd = cfg.enable && (phase >= phaseMax);
    sampleDue = periodEnd && (repCnt >= cfg.repM1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cfg <= '0;
    else if (wrCtrl) cfg <= ctrl_t'(ctrlWdata);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= '0;
      repCnt <= '0;
    end else if (!cfg.enable) begin
      phase  <= '0;
      repCnt <= '0;
    end else if (periodEnd) begin
      phase  <= '0;
      repCnt <= sampleDue ? '0 : repCnt + 1'b1;
    end else begin
      phase  <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bufValid <= 1'b0;
    else       bufValid <= (bufValid && !sampleDue) || wrSample;
  end

  assign stb   = '{bufWrite: wrSample, bufWide: regWide, load: sampleDue && bufValid};
  assign txReq = cfg.enable && !bufValid;

  p_off_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> (phase == '0));
  p_load_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (phase == '0));
  p_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufWrite |=> !txReq);
endmodule

// File: rtl/pwmdac_datapath.sv
module pwmdac_datapath
  import pwmdac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             cfg,
  input  logic [CNT_W-1:0]  phase,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  output logic              pwmLeft,
  output logic              pwmRight
);
  localparam int NCH = 2;

  logic [SMP_W-1:0] bufS [NCH];
  logic [SMP_W-1:0] curS [NCH];
  logic [NCH-1:0]   pwm;
  logic             unusedRep;

  assign unusedRep = ^cfg.repM1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufS[0] <= '0;
      bufS[1] <= '0;
    end else if (stb.bufWrite) begin
      bufS[0] <= wdata[SMP_W-1:0];
      bufS[1] <= stb.bufWide ? wdata[DATA_W-1:SMP_W] : wdata[SMP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curS[0] <= '0;
      curS[1] <= '0;
    end else if (stb.load) begin
      curS[0] <= bufS[0];
      curS[1] <= bufS[1];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [SMP_W-1:0] src;
    assign src = cfg.swap ? curS[NCH-1-ch] : curS[ch];
    pwmdac_chan u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .enable   (cfg.enable),
      .hiRes    (cfg.hiRes),
      .align    (cfg.align),
      .signMode (cfg.signMode),
      .shift    (cfg.shift),
      .raw      (src),
      .phase    (phase),
      .pwm      (pwm[ch])
    );
  end

  assign pwmLeft  = pwm[0];
  assign pwmRight = pwm[1];

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> ($stable(curS[0]) && $stable(curS[1])));
endmodule

// File: rtl/pwmdac_top.sv
module pwmdac_top
  import pwmdac_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWide,
  input  logic [DATA_W-1:0] regWdata,
  output logic              txReq,
  output logic              pwmLeft,
  output logic              pwmRight
);
  ctrl_t            cfg;
  logic [CNT_W-1:0] phase;
  strobe_t          stb;

  pwmdac_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWide   (regWide),
    .ctrlWdata (regWdata[CTRL_W-1:0]),
    .cfg       (cfg),
    .phase     (phase),
    .stb       (stb),
    .txReq     (txReq)
  );

  pwmdac_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .phase    (phase),
    .stb      (stb),
    .wdata    (regWdata),
    .pwmLeft  (pwmLeft),
    .pwmRight (pwmRight)
  );
endmodule

// File: tb/pwmdac_top_test.sv
module pwmdac_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWide = 1'b0;
  logic [31:0] regWdata = '0;
  logic        txReq, pwmLeft, pwmRight;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] raw;   // {right, left}
    string       tag;
  } exp_t;
  exp_t expQ[$];

  // configuration the monitor uses to derive expected waveforms
  int  benchP = 256;
  bit  benchHi = 0, benchSign = 0, benchSwap = 0;
  int  benchShift = 0, benchAlign = 0;
  bit  monOn = 0;
  int  monTarget = 0;
  int  periodsDone = 0;
  int  ph = 0, hiL = 0, hiR = 0, firstL = 0, firstR = 0;

  always #4 clk = ~clk;

  pwmdac_top uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWide(regWide), .regWdata(regWdata), .txReq(txReq),
    .pwmLeft(pwmLeft), .pwmRight(pwmRight)
  );

  function automatic int dutyOf(logic [15:0] raw);
    logic [15:0] x;
    x = raw ^ (benchSign ? 16'h8000 : 16'h0000);
    x = x << benchShift;
    return benchHi ? int'(x[15:6]) : int'(x[15:8]);
  endfunction

  function automatic int startOf(int d);
    if (d == 0) return benchP;
    if (benchAlign == 0) return 0;
    if (benchAlign == 1) return benchP - d;
    return (benchP - d) / 2;
  endfunction

  function automatic logic [31:0] mkCtrl(bit en, bit hi, int align, int rep,
                                         bit swap, bit sgn, int shift);
    logic [31:0] c;
    c = '0;
    c[0] = en; c[1] = hi; c[3:2] = align[1:0];
    c[12:4] = 9'(rep - 1); c[13] = swap; c[14] = sgn; c[17:15] = shift[2:0];
    return c;
  endfunction

  task automatic check(string req, int act, int expv, string what);
    testsRun++;
    if (act != expv) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic wide, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWide = wide; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic startRun(int n, logic [31:0] ctrlWord);
    periodsDone = 0; monTarget = n;
    ph = 0; hiL = 0; hiR = 0; firstL = benchP; firstR = benchP;
    regWrite(3'd4, 1'b1, ctrlWord);
    @(posedge clk);
    monOn = 1;
  endtask

  task automatic pushExp(logic [31:0] raw, string tag);
    exp_t e;
    e.raw = raw; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: measures every PWM period and compares with the scoreboard
  always @(negedge clk) begin
    if (monOn) begin
      if (pwmLeft)  begin hiL++; if (firstL == benchP) firstL = ph; end
      if (pwmRight) begin hiR++; if (firstR == benchP) firstR = ph; end
      ph++;
      if (ph == benchP) begin
        if (expQ.size() == 0) begin
          check("R9", 1, 0, "unexpected period");
        end else begin
          exp_t e;
          logic [15:0] sl, sr;
          int dl, dr;
          e = expQ.pop_front();
          sl = benchSwap ? e.raw[31:16] : e.raw[15:0];
          sr = benchSwap ? e.raw[15:0]  : e.raw[31:16];
          dl = dutyOf(sl); dr = dutyOf(sr);
          check(e.tag, hiL, dl, "left high clocks");
          check(e.tag, hiR, dr, "right high clocks");
          check("R4", firstL, startOf(dl), "left first high clock");
          check("R4", firstR, startOf(dr), "right first high clock");
        end
        periodsDone++;
        ph = 0; hiL = 0; hiR = 0; firstL = benchP; firstR = benchP;
        if (periodsDone == monTarget) monOn = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", pwmLeft, 0, "left pin after reset");
    check("R1", pwmRight, 0, "right pin after reset");
    check("R1", txReq, 0, "txReq after reset");

    // Phase A: 8-bit, left aligned, one period per sample
    benchP = 256; benchHi = 0; benchSign = 0; benchSwap = 0; benchShift = 0; benchAlign = 0;
    regWrite(3'd0, 1'b1, {16'hC000, 16'h4000});
    pushExp(32'h0, "R1");                       // active sample still zero
    pushExp({16'hC000, 16'h4000}, "R6");        // wide write, left in low half
    pushExp({16'hC000, 16'h4000}, "R9");        // underrun holds
    pushExp({16'h8000, 16'h8000}, "R6");        // narrow write drives both
    startRun(4, mkCtrl(1, 0, 0, 1, 0, 0, 0));
    wait (periodsDone == 1);
    @(negedge clk);
    check("R9", txReq, 1, "txReq with empty buffer");
    wait (periodsDone == 2);
    regWrite(3'd0, 1'b0, 32'h1234_8000);
    check("R9", txReq, 0, "txReq after refill");
    wait (periodsDone == 4);
    regWrite(3'd4, 1'b1, mkCtrl(0, 0, 0, 1, 0, 0, 0));
    @(negedge clk);
    check("R2", pwmLeft, 0, "left pin while disabled");
    check("R2", pwmRight, 0, "right pin while disabled");
    check("R2", txReq, 0, "txReq while disabled");

    // Phase B: right aligned, two periods per sample, swap, signed, shift 1
    benchAlign = 1; benchSign = 1; benchSwap = 1; benchShift = 1;
    regWrite(3'd0, 1'b1, {16'hF000, 16'h1000});
    pushExp({16'h8000, 16'h8000}, "R2");        // held across disable
    pushExp({16'h8000, 16'h8000}, "R2");
    pushExp({16'hF000, 16'h1000}, "R8");
    pushExp({16'hF000, 16'h1000}, "R5");        // second repeat
    pushExp({16'hF000, 16'h1000}, "R9");        // underrun on multi-period boundary
    pushExp({16'hF000, 16'h1000}, "R9");
    startRun(6, mkCtrl(1, 0, 1, 2, 1, 1, 1));
    wait (periodsDone == 6);
    regWrite(3'd4, 1'b1, mkCtrl(0, 0, 1, 2, 1, 1, 1));
    @(negedge clk);
    check("R2", pwmLeft | pwmRight, 0, "pins after second disable");

    // Phase C: 10-bit, centre aligned
    benchP = 1024; benchHi = 1; benchAlign = 2; benchSign = 0; benchSwap = 0; benchShift = 0;
    regWrite(3'd0, 1'b1, {16'h0040, 16'hFFFF});
    pushExp({16'hF000, 16'h1000}, "R7");
    pushExp({16'h0040, 16'hFFFF}, "R3");
    startRun(2, mkCtrl(1, 1, 2, 1, 0, 0, 0));
    wait (periodsDone == 2);
    regWrite(3'd4, 1'b1, 32'h0);

    // Phase D: 8-bit, reserved alignment code, maximum shift
    benchP = 256; benchHi = 0; benchAlign = 3; benchShift = 7;
    regWrite(3'd0, 1'b0, 32'h0000_0003);
    pushExp({16'h0040, 16'hFFFF}, "R7");
    pushExp({16'h0003, 16'h0003}, "R7");
    startRun(2, mkCtrl(1, 0, 3, 1, 0, 0, 7));
    wait (periodsDone == 2);
    check("R9", expQ.size(), 0, "scoreboard drained");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule